// File: doc/BRIEF.md
# Performance Counter Bank Read Unit

This unit holds a bank of event counters and answers counter-read requests that a processor pipeline issues. The bank has three classes. The wide general counters can also be read in a fast mode. A group of 32-bit narrow counters sits directly above the wide ones in the same index space. A small set of fixed-function counters forms a class of its own. Every counter advances by one on each cycle that its event input is asserted while its enable bit is set. A separate test write port can load any counter.

A request carries a 32-bit selector, the current privilege level, a protected-mode flag, a user-read-enable flag and a lock-prefix flag. One cycle after the request, the unit returns a registered response. The response is either the counter value split into a 32-bit low word and a zero-extended high word, or a fault flag: general-protection or undefined-opcode. Faulting responses carry all-zero data.

The counter width is set by the most significant counter bit parameter, which is normally 39 or 47. By default the bank has 18 wide general counters (indices 0 to 17), 8 narrow counters (indices 18 to 25) and 3 fixed counters (indices 0 to 2).

Top module: `pmc_read_unit`

## Requirements
- R1: Selector bit 30 picks the class. A value of 1 addresses the fixed counters and a value of 0 addresses the general and narrow counters. Selector bits 29:0 hold the index inside the class.
- R2: A read is allowed when the user-read-enable flag is 1, or the privilege level is 0, or protected mode is off. Any other request returns a general-protection fault (rsp_gp=1).
- R3: A request whose 30-bit index is at or above the class size (the fixed counter count, or the general plus narrow counter count) returns a general-protection fault.
- R4: A full read places counter bits 31:0 in rsp_lo. It places bits from the top counter bit down to bit 32 in rsp_hi, zero-extended above the counter width.
- R5: On a wide general counter, selector bit 31 set makes a fast read: rsp_lo holds bits 31:0 and rsp_hi is 0. Fixed counters ignore bit 31 and always return the full value.
- R6: The narrow counters are 32 bits wide. A read of one always returns rsp_hi = 0.
- R7: A request with the lock flag set returns an undefined-opcode fault (rsp_ud=1). This takes precedence over every other check.
- R8: The privilege fault is checked before the index fault. At most one fault flag is set at a time. A faulting response has rsp_lo = rsp_hi = 0, and no counter changes because of it.
- R9: A counter increments by one on every cycle that its event and enable inputs are both 1. Wide counters wrap to 0 at 2^(CTR_MSB+1) and narrow counters wrap to 0 at 2^32.
- R10: rsp_valid is 1 in exactly the cycle after a cycle with req_valid=1. The data is the counter value held before that request's clock edge, so an increment on the same edge shows only on a later read.
- R11: A test write (dbg_we=1) loads the addressed counter with dbg_data truncated to the counter's width. On the same edge it overrides an increment. A write to a nonexistent index changes nothing.
- R12: Reset clears every counter and all response outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request strobe |
| req_sel | input | 32 | Selector: bit 31 fast read, bit 30 class, bits 29:0 index |
| req_cpl | input | 2 | Current privilege level |
| req_pmode | input | 1 | Protected mode active |
| req_uen | input | 1 | User counter read enable |
| req_lock | input | 1 | Lock prefix present |
| evt_gen | input | NUM_GP+NUM_SP | Event inputs of the general and narrow counters |
| en_gen | input | NUM_GP+NUM_SP | Count enables of the general and narrow counters |
| evt_fix | input | NUM_FX | Event inputs of the fixed counters |
| en_fix | input | NUM_FX | Count enables of the fixed counters |
| dbg_we | input | 1 | Test write strobe |
| dbg_fix | input | 1 | Test write targets the fixed class |
| dbg_idx | input | IDXW | Test write index |
| dbg_data | input | CTR_MSB+1 | Test write value |
| rsp_valid | output | 1 | Response valid |
| rsp_lo | output | 32 | Result low word |
| rsp_hi | output | 32 | Result high word |
| rsp_gp | output | 1 | General-protection fault |
| rsp_ud | output | 1 | Undefined-opcode fault |

## Verification
The only way to see a counter's state at the ports is a read. A wrong increment, a missed wrap or a lost test write therefore stays hidden until that counter is next selected, and then shows as a wrong rsp_lo or rsp_hi one cycle after the request. Decoding and permission errors show on the very next cycle as a wrong fault flag or a nonzero faulting payload. The bench keeps a behavioural model of every counter and compares all response outputs on every cycle. It mixes many short reads with increments and writes so that a corrupted counter is read within a few cycles.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [2:0] {
        RD_NONE,
        RD_UD,
        RD_PRIV,
        RD_RANGE,
        RD_FULL,
        RD_LOW
    } rd_kind_e;

    typedef struct packed {
        rd_kind_e    kind;
        logic        fix;
        logic [29:0] idx;
    } pmc_dec_t;

    typedef struct packed {
        logic        valid;
        logic [31:0] lo;
        logic [31:0] hi;
        logic        gp;
        logic        ud;
    } pmc_rsp_t;

endpackage

// File: rtl/pmc_ctr.sv
module pmc_ctr #(
    parameter int W = 40
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] val
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (ld) begin
            cnt_d = ld_val;
        end else if (inc) begin
            cnt_d = cnt_q + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign val = cnt_q;

    p_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && inc && !ld && (&cnt_q)) |=> (cnt_q == '0));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !inc && !ld) |=> $stable(cnt_q));

    p_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && ld) |=> (cnt_q == $past(ld_val)));

endmodule

// File: rtl/pmc_counter_bank.sv
module pmc_counter_bank #(
    parameter int NUM_GP = 18,
    parameter int NUM_SP = 8,
    parameter int NUM_FX = 3,
    parameter int CW     = 40,
    parameter int SPW    = 32,
    parameter int IDXW   = 5,
    localparam int NGEN  = NUM_GP + NUM_SP
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NGEN-1:0] evt_gen,
    input  logic [NGEN-1:0] en_gen,
    input  logic [NUM_FX-1:0] evt_fix,
    input  logic [NUM_FX-1:0] en_fix,
    input  logic            wr_en,
    input  logic            wr_fix,
    input  logic [IDXW-1:0] wr_idx,
    input  logic [CW-1:0]   wr_data,
    output logic [CW-1:0]   gen_val [NGEN],
    output logic [CW-1:0]   fix_val [NUM_FX]
);

    for (genvar g = 0; g < NGEN; g++) begin : g_gen
        logic hit;
        assign hit = wr_en && !wr_fix && (wr_idx == IDXW'(g));
        if (g < NUM_GP) begin : g_wide
            pmc_ctr #(.W(CW)) u_ctr (
                .clk    (clk),
                .rst_n  (rst_n),
                .inc    (evt_gen[g] && en_gen[g]),
                .ld     (hit),
                .ld_val (wr_data),
                .val    (gen_val[g])
            );
        end else begin : g_narrow
            logic [SPW-1:0] nv;
            pmc_ctr #(.W(SPW)) u_ctr (
                .clk    (clk),
                .rst_n  (rst_n),
                .inc    (evt_gen[g] && en_gen[g]),
                .ld     (hit),
                .ld_val (wr_data[SPW-1:0]),
                .val    (nv)
            );
            assign gen_val[g] = CW'(nv);
        end
    end

    for (genvar f = 0; f < NUM_FX; f++) begin : g_fix
        pmc_ctr #(.W(CW)) u_ctr (
            .clk    (clk),
            .rst_n  (rst_n),
            .inc    (evt_fix[f] && en_fix[f]),
            .ld     (wr_en && wr_fix && (wr_idx == IDXW'(f))),
            .ld_val (wr_data),
            .val    (fix_val[f])
        );
    end

endmodule

// File: rtl/pmc_sel_decode.sv
module pmc_sel_decode import pmc_pkg::*; #(
    parameter int NUM_GP = 18,
    parameter int NUM_SP = 8,
    parameter int NUM_FX = 3,
    localparam int NGEN  = NUM_GP + NUM_SP
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        valid,
    input  logic [31:0] sel,
    input  logic [1:0]  cpl,
    input  logic        pmode,
    input  logic        uen,
    input  logic        lock,
    output pmc_dec_t    dec
);

    logic allowed;
    logic fast;
    logic cls_fix;
    logic [29:0] index;

    always_comb begin
        allowed = uen || (cpl == 2'd0) || !pmode;
        fast    = sel[31];
        cls_fix = sel[30];
        index   = sel[29:0];

        dec.fix  = cls_fix;
        dec.idx  = index;
        dec.kind = RD_NONE;
        if (!valid) begin
            dec.kind = RD_NONE;
        end else if (lock) begin
            dec.kind = RD_UD;
        end else if (!allowed) begin
            dec.kind = RD_PRIV;
        end else if (cls_fix) begin
            dec.kind = (index < 30'(NUM_FX)) ? RD_FULL : RD_RANGE;
        end else if (index < 30'(NUM_GP)) begin
            dec.kind = fast ? RD_LOW : RD_FULL;
        end else if (index < 30'(NGEN)) begin
            dec.kind = RD_LOW;
        end else begin
            dec.kind = RD_RANGE;
        end
    end

    p_lock_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && lock) |-> (dec.kind == RD_UD));

    p_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec.kind == RD_FULL || dec.kind == RD_LOW) |->
            (dec.fix ? (dec.idx < 30'(NUM_FX)) : (dec.idx < 30'(NGEN))));

endmodule

// File: rtl/pmc_rsp_fmt.sv
module pmc_rsp_fmt import pmc_pkg::*; #(
    parameter int NUM_GP = 18,
    parameter int NUM_SP = 8,
    parameter int NUM_FX = 3,
    parameter int CW     = 40,
    localparam int NGEN  = NUM_GP + NUM_SP
) (
    input  pmc_dec_t      dec,
    input  logic [CW-1:0] gen_val [NGEN],
    input  logic [CW-1:0] fix_val [NUM_FX],
    output pmc_rsp_t      rsp
);

    logic [CW-1:0] gv, fv, pick;

    always_comb begin
        gv = '0;
        for (int i = 0; i < NGEN; i++) begin
            if (dec.idx == 30'(i)) gv = gen_val[i];
        end
        fv = '0;
        for (int i = 0; i < NUM_FX; i++) begin
            if (dec.idx == 30'(i)) fv = fix_val[i];
        end
        pick = dec.fix ? fv : gv;

        rsp       = '0;
        rsp.valid = (dec.kind != RD_NONE);
        rsp.ud    = (dec.kind == RD_UD);
        rsp.gp    = (dec.kind == RD_PRIV) || (dec.kind == RD_RANGE);
        if (dec.kind == RD_FULL || dec.kind == RD_LOW) begin
            rsp.lo = pick[31:0];
        end
        if (dec.kind == RD_FULL) begin
            rsp.hi = 32'(pick[CW-1:32]);
        end
    end

endmodule

// File: rtl/pmc_read_unit.sv
module pmc_read_unit import pmc_pkg::*; #(
    parameter int CTR_MSB = 39,
    parameter int NUM_GP  = 18,
    parameter int NUM_SP  = 8,
    parameter int NUM_FX  = 3,
    localparam int CW     = CTR_MSB + 1,
    localparam int NGEN   = NUM_GP + NUM_SP,
    localparam int IDXW   = $clog2((NGEN > NUM_FX) ? NGEN : NUM_FX)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [31:0]       req_sel,
    input  logic [1:0]        req_cpl,
    input  logic              req_pmode,
    input  logic              req_uen,
    input  logic              req_lock,
    input  logic [NGEN-1:0]   evt_gen,
    input  logic [NGEN-1:0]   en_gen,
    input  logic [NUM_FX-1:0] evt_fix,
    input  logic [NUM_FX-1:0] en_fix,
    input  logic              dbg_we,
    input  logic              dbg_fix,
    input  logic [IDXW-1:0]   dbg_idx,
    input  logic [CW-1:0]     dbg_data,
    output logic              rsp_valid,
    output logic [31:0]       rsp_lo,
    output logic [31:0]       rsp_hi,
    output logic              rsp_gp,
    output logic              rsp_ud
);

    logic [CW-1:0] gen_val [NGEN];
    logic [CW-1:0] fix_val [NUM_FX];
    pmc_dec_t      dec;
    pmc_rsp_t      rsp_d, rsp_q;

    pmc_counter_bank #(
        .NUM_GP (NUM_GP),
        .NUM_SP (NUM_SP),
        .NUM_FX (NUM_FX),
        .CW     (CW),
        .SPW    (32),
        .IDXW   (IDXW)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_gen (evt_gen),
        .en_gen  (en_gen),
        .evt_fix (evt_fix),
        .en_fix  (en_fix),
        .wr_en   (dbg_we),
        .wr_fix  (dbg_fix),
        .wr_idx  (dbg_idx),
        .wr_data (dbg_data),
        .gen_val (gen_val),
        .fix_val (fix_val)
    );

    pmc_sel_decode #(
        .NUM_GP (NUM_GP),
        .NUM_SP (NUM_SP),
        .NUM_FX (NUM_FX)
    ) u_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .valid (req_valid),
        .sel   (req_sel),
        .cpl   (req_cpl),
        .pmode (req_pmode),
        .uen   (req_uen),
        .lock  (req_lock),
        .dec   (dec)
    );

    pmc_rsp_fmt #(
        .NUM_GP (NUM_GP),
        .NUM_SP (NUM_SP),
        .NUM_FX (NUM_FX),
        .CW     (CW)
    ) u_fmt (
        .dec     (dec),
        .gen_val (gen_val),
        .fix_val (fix_val),
        .rsp     (rsp_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_lo    = rsp_q.lo;
    assign rsp_hi    = rsp_q.hi;
    assign rsp_gp    = rsp_q.gp;
    assign rsp_ud    = rsp_q.ud;

    p_rsp_timing_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (rsp_valid == $past(req_valid)));

    p_lock_ud_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && req_valid && req_lock) |=> (rsp_ud && !rsp_gp));

    p_priv_gp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && req_valid && !req_lock && req_pmode && !req_uen && (req_cpl != 2'd0))
            |=> rsp_gp);

    p_fast_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && req_valid && !req_sel[30] && req_sel[31]) |=> (rsp_hi == 32'd0));

    p_one_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({rsp_gp, rsp_ud}) <= 1);

    p_fault_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_gp || rsp_ud) |-> (rsp_lo == 32'd0 && rsp_hi == 32'd0));

    p_hi_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ((rsp_hi >> (CW - 32)) == 32'd0));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_gp && !rsp_ud && rsp_lo == 32'd0 && rsp_hi == 32'd0));

endmodule

// File: tb/pmc_read_unit_bench.sv
module pmc_read_unit_bench;

    localparam int CTR_MSB = 39;
    localparam int CW      = CTR_MSB + 1;
    localparam int NUM_GP  = 18;
    localparam int NUM_SP  = 8;
    localparam int NUM_FX  = 3;
    localparam int NGEN    = NUM_GP + NUM_SP;
    localparam int IDXW    = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [31:0]       req_sel = '0;
    logic [1:0]        req_cpl = '0;
    logic              req_pmode = 1'b0;
    logic              req_uen = 1'b0;
    logic              req_lock = 1'b0;
    logic [NGEN-1:0]   evt_gen = '0;
    logic [NGEN-1:0]   en_gen = '0;
    logic [NUM_FX-1:0] evt_fix = '0;
    logic [NUM_FX-1:0] en_fix = '0;
    logic              dbg_we = 1'b0;
    logic              dbg_fix = 1'b0;
    logic [IDXW-1:0]   dbg_idx = '0;
    logic [CW-1:0]     dbg_data = '0;
    logic              rsp_valid;
    logic [31:0]       rsp_lo, rsp_hi;
    logic              rsp_gp, rsp_ud;

    always #10 clk = ~clk;

    pmc_read_unit #(
        .CTR_MSB (CTR_MSB),
        .NUM_GP  (NUM_GP),
        .NUM_SP  (NUM_SP),
        .NUM_FX  (NUM_FX)
    ) u_pmc_read_unit (.*);

    logic [63:0] m_gen [NGEN];
    logic [63:0] m_fix [NUM_FX];
    logic        e_valid, e_gp, e_ud;
    logic [31:0] e_lo, e_hi;
    string       e_tag;
    int          vectors = 0;
    int          miscompares = 0;
    bit          done = 0;

    function automatic logic [63:0] gmask(int i);
        return (i < NUM_GP) ? ((64'd1 << CW) - 64'd1) : 64'h0000_0000_FFFF_FFFF;
    endfunction

    task automatic predict(string tag);
        string t;
        logic [29:0] idx;
        logic [63:0] v;
        e_valid = 0; e_gp = 0; e_ud = 0; e_lo = '0; e_hi = '0;
        t = "R10";
        idx = req_sel[29:0];
        if (!rst_n) begin
            t = "R12";
        end else if (req_valid) begin
            e_valid = 1;
            if (req_lock) begin
                e_ud = 1; t = "R7";
            end else if (req_pmode && req_cpl != 2'd0 && !req_uen) begin
                e_gp = 1; t = "R2";
            end else if (req_sel[30]) begin
                if (idx < 30'(NUM_FX)) begin
                    v = m_fix[idx]; e_lo = v[31:0]; e_hi = v[63:32]; t = "R1";
                end else begin
                    e_gp = 1; t = "R3";
                end
            end else if (idx < 30'(NUM_GP)) begin
                v = m_gen[idx]; e_lo = v[31:0];
                e_hi = req_sel[31] ? 32'd0 : v[63:32];
                t = req_sel[31] ? "R5" : "R4";
            end else if (idx < 30'(NGEN)) begin
                v = m_gen[idx]; e_lo = v[31:0]; e_hi = 32'd0; t = "R6";
            end else begin
                e_gp = 1; t = "R3";
            end
        end
        e_tag = (tag != "") ? tag : t;
    endtask

    task automatic update_model();
        if (!rst_n) begin
            foreach (m_gen[i]) m_gen[i] = '0;
            foreach (m_fix[i]) m_fix[i] = '0;
            return;
        end
        for (int i = 0; i < NGEN; i++) begin
            if (dbg_we && !dbg_fix && int'(dbg_idx) == i)
                m_gen[i] = 64'(dbg_data) & gmask(i);
            else if (evt_gen[i] && en_gen[i])
                m_gen[i] = (m_gen[i] + 64'd1) & gmask(i);
        end
        for (int i = 0; i < NUM_FX; i++) begin
            if (dbg_we && dbg_fix && int'(dbg_idx) == i)
                m_fix[i] = 64'(dbg_data) & gmask(0);
            else if (evt_fix[i] && en_fix[i])
                m_fix[i] = (m_fix[i] + 64'd1) & gmask(0);
        end
    endtask

    // Called at a falling edge once the inputs for the coming rising edge are set.
    task automatic cycle(string tag);
        vectors++;
        if (rsp_valid !== e_valid || rsp_lo !== e_lo || rsp_hi !== e_hi ||
            rsp_gp !== e_gp || rsp_ud !== e_ud) begin
            miscompares++;
            $display("FAIL %s: got v=%0b lo=%h hi=%h gp=%0b ud=%0b expected v=%0b lo=%h hi=%h gp=%0b ud=%0b",
                     e_tag, rsp_valid, rsp_lo, rsp_hi, rsp_gp, rsp_ud,
                     e_valid, e_lo, e_hi, e_gp, e_ud);
        end
        predict(tag);
        update_model();
        @(negedge clk);
    endtask

    task automatic quiet();
        req_valid = 0; req_lock = 0; req_uen = 0; req_cpl = 0; req_pmode = 1;
        evt_gen = '0; evt_fix = '0; dbg_we = 0;
    endtask

    task automatic rd(logic fix, int idx, logic fast, string tag);
        quiet();
        req_valid = 1;
        req_sel = {fast, fix, 30'(idx)};
        cycle(tag);
    endtask

    task automatic wr(logic fix, int idx, logic [CW-1:0] data, string tag);
        quiet();
        dbg_we = 1; dbg_fix = fix; dbg_idx = IDXW'(idx); dbg_data = data;
        cycle(tag);
    endtask

    task automatic priv(int idx, logic [1:0] cpl, logic pm, logic uen, logic lock, string tag);
        quiet();
        req_valid = 1; req_sel = {2'b00, 30'(idx)};
        req_cpl = cpl; req_pmode = pm; req_uen = uen; req_lock = lock;
        cycle(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        foreach (m_gen[i]) m_gen[i] = '0;
        foreach (m_fix[i]) m_fix[i] = '0;
        e_valid = 0; e_gp = 0; e_ud = 0; e_lo = '0; e_hi = '0; e_tag = "R12";
        @(negedge clk);
        // R12: outputs stay cleared in reset even with a request present
        req_valid = 1; req_sel = '0;
        repeat (3) cycle("R12");
        rst_n = 1;
        quiet();
        cycle("R12");
        rd(0, 0, 0, "R12");
        rd(1, 2, 0, "R12");
        // R11: test writes, then full and fast reads
        wr(0, 0, 40'hA5_1234_5678, "R11");
        wr(0, 17, 40'hFF_FFFF_FFFF, "R11");
        wr(0, 20, 40'hC3_8765_4321, "R11");
        wr(1, 1, 40'h5A_0BAD_CAFE, "R11");
        wr(1, 3, 40'h11_1111_1111, "R11");
        rd(0, 0, 0, "R4");
        rd(0, 0, 1, "R5");
        rd(1, 1, 0, "R1");
        rd(1, 1, 1, "R5");
        rd(0, 20, 0, "R6");
        rd(0, 20, 1, "R6");
        rd(0, 17, 0, "R4");
        // R9: wrap of a wide and a narrow counter
        quiet(); evt_gen[17] = 1; en_gen[17] = 1; evt_gen[20] = 1; en_gen[20] = 1;
        cycle("R9");
        wr(0, 20, 40'h00_FFFF_FFFF, "R9");
        quiet(); evt_gen[20] = 1; cycle("R9");
        rd(0, 17, 0, "R9");
        rd(0, 20, 0, "R9");
        quiet(); evt_gen[3] = 1; en_gen[3] = 0; cycle("R9");
        rd(0, 3, 0, "R9");
        // R10: a read and an increment on the same edge
        quiet(); req_valid = 1; req_sel = 32'd0; evt_gen[0] = 1; en_gen[0] = 1;
        cycle("R10");
        rd(0, 0, 0, "R10");
        // R11: write beats increment
        quiet(); dbg_we = 1; dbg_fix = 0; dbg_idx = 5'd5; dbg_data = 40'h7; evt_gen[5] = 1; en_gen[5] = 1;
        cycle("R11");
        rd(0, 5, 0, "R11");
        // R2 permission combinations
        priv(0, 2'd3, 1, 0, 0, "R2");
        priv(0, 2'd3, 1, 1, 0, "R2");
        priv(0, 2'd3, 0, 0, 0, "R2");
        priv(0, 2'd0, 1, 0, 0, "R2");
        priv(0, 2'd1, 1, 0, 0, "R2");
        // R3 index range
        rd(0, NGEN, 0, "R3");
        rd(1, NUM_FX, 0, "R3");
        rd(0, 32'h2000_0000, 0, "R3");
        rd(1, 32'h2000_0001, 0, "R3");
        rd(0, NGEN - 1, 0, "R6");
        // R7 and R8 priorities
        priv(0, 2'd3, 1, 0, 1, "R7");
        priv(99, 2'd0, 1, 0, 1, "R7");
        priv(99, 2'd2, 1, 0, 0, "R8");
        rd(0, 0, 0, "R8");
        // random mix
        for (int n = 0; n < 6000; n++) begin
            logic fix;
            logic [29:0] idx;
            quiet();
            req_valid = ($urandom_range(0, 3) != 0);
            fix = ($urandom_range(0, 3) == 0);
            idx = 30'($urandom_range(0, fix ? NUM_FX + 1 : NGEN + 2));
            if ($urandom_range(0, 15) == 0) idx = idx | 30'h2000_0000;
            req_sel = {1'($urandom_range(0, 1)), fix, idx};
            req_cpl = 2'($urandom_range(0, 3));
            req_pmode = 1'($urandom_range(0, 1));
            req_uen = 1'($urandom_range(0, 1));
            req_lock = ($urandom_range(0, 7) == 0);
            evt_gen = NGEN'({$urandom, $urandom});
            en_gen = NGEN'({$urandom, $urandom});
            evt_fix = NUM_FX'($urandom);
            en_fix = NUM_FX'($urandom);
            dbg_we = ($urandom_range(0, 7) == 0);
            dbg_fix = ($urandom_range(0, 3) == 0);
            dbg_idx = IDXW'($urandom_range(0, dbg_fix ? NUM_FX : NGEN - 1));
            dbg_data = ($urandom_range(0, 1) == 1) ? ('1 - CW'($urandom_range(0, 3)))
                                                  : CW'({$urandom, $urandom});
            cycle("");
        end
        quiet();
        cycle("");
        cycle("");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule